// File: doc/BRIEF.md
# Read Response Reordering Buffer

This block sits between a requester that issues reads and a read interconnect that may answer them out of order. Each read that the requester issues takes a free slot. The slot number is sent as the read's transaction ID, so no two reads in flight carry the same ID. The slots are handed out from a circular tail pointer, which also records the order in which the reads were issued.

Responses come back tagged with an ID, in any order. Each one is written into the slot its ID names. A response that arrives early, while an older read is still waiting, stays in its slot. Only the oldest slot, at the head pointer, can hand its data to the requester, and only after its response has arrived. The requester therefore sees the data in the order it issued the reads. When every slot is taken, the block stops accepting requests. Each slot already has room for its data, so the response channel never pushes back. A response whose ID names no waiting slot is thrown away and raises a one-cycle error flag.

Top module: `read_reorder_buf`

## Requirements
- R1: After reset, issued reads receive IDs 0, 1, ..., DEPTH-1 and then wrap back to 0, in issue order. The ID is driven on `ar_id` (ID_W bits, zero-extended slot number).
- R2: No ID is presented on the address channel while a read carrying that ID is still held in the buffer.
- R3: While DEPTH reads are held and none has been delivered, `req_ready` and `ar_valid` are both low, even when `req_valid` is high.
- R4: `r_ready` is high in every cycle, including during reset.
- R5: A response whose ID names a waiting, unfilled slot is stored. If that slot is the oldest, `rsp_valid` rises in the cycle after the response beat.
- R6: `rsp_data` and `rsp_resp` are delivered in the order the reads were issued, whatever order the responses arrive in. Early responses are held, and `rsp_valid` stays low while the oldest read has no response.
- R7: While `rsp_valid` is high and `rsp_ready` is low, `rsp_valid`, `rsp_data` and `rsp_resp` hold their values into the next cycle.
- R8: A response beat whose ID is DEPTH or larger, names a slot with no read in flight, or names a slot that already holds a response is dropped, producing no delivery. `rsp_err` is high for exactly the one cycle after such a beat, and is low otherwise.
- R9: Immediately after reset, `rsp_valid` and `rsp_err` are low and `req_ready` equals `ar_ready`.
- R10: While a slot is free, `ar_valid` follows `req_valid`, `req_ready` follows `ar_ready`, and `ar_addr` equals `req_addr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Requester offers a read |
| req_ready | output | 1 | Read accepted this cycle when high with req_valid |
| req_addr | input | ADDR_W | Read address from requester |
| ar_valid | output | 1 | Read address valid toward interconnect |
| ar_ready | input | 1 | Interconnect accepts read address |
| ar_id | output | ID_W | Transaction ID (slot number) |
| ar_addr | output | ADDR_W | Read address toward interconnect |
| r_valid | input | 1 | Response beat valid |
| r_ready | output | 1 | Response accept, always high |
| r_id | input | ID_W | ID of the response beat |
| r_data | input | DATA_W | Response data |
| r_resp | input | RESP_W | Response status |
| rsp_valid | output | 1 | In-order response available to requester |
| rsp_ready | input | 1 | Requester takes the response |
| rsp_data | output | DATA_W | In-order response data |
| rsp_resp | output | RESP_W | In-order response status |
| rsp_err | output | 1 | One-cycle flag for a dropped, unmatched response |

## Verification
The assertions check several rules on every cycle. An ID is never reused while its read is in flight. A full buffer always blocks new requests. Only a filled head slot can present data. The occupancy changes by exactly one per issue and one per delivery. A response held back by the requester does not move. A dropped beat is followed by exactly one error cycle. Two behaviours need the bench's own scenarios: the data arriving in issue order after responses come back reversed or shuffled, and the IDs wrapping around the ring. These scenarios use a model that remembers the issue order and the address behind each ID.

// File: rtl/rob_pkg.sv
package rob_pkg;

  // Advance a ring pointer, wrapping at depth.
  function automatic int unsigned ring_next(int unsigned p, int unsigned depth);
    return (p + 1 == depth) ? 0 : p + 1;
  endfunction

  // An ID names a slot only when it is below the slot count.
  function automatic bit id_in_range(int unsigned id, int unsigned depth);
    return id < depth;
  endfunction

  // Occupancy after one cycle of issues and deliveries.
  function automatic int unsigned occ_next(int unsigned occ, bit inc, bit dec);
    return occ + int'(inc) - int'(dec);
  endfunction

endpackage

// File: rtl/rob_ring_ctrl.sv
module rob_ring_ctrl #(
  parameter int DEPTH = 8,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic             pop,
  output logic [PTR_W-1:0] head,
  output logic [PTR_W-1:0] tail,
  output logic [CNT_W-1:0] count,
  output logic             full
);
  import rob_pkg::*;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      head  <= '0;
      tail  <= '0;
      count <= '0;
    end else begin
      if (push) tail <= PTR_W'(ring_next(32'(tail), DEPTH));
      if (pop)  head <= PTR_W'(ring_next(32'(head), DEPTH));
      count <= CNT_W'(occ_next(32'(count), push, pop));
    end
  end

  assign full = (count == CNT_W'(DEPTH));

endmodule

// File: rtl/rob_slot_bank.sv
module rob_slot_bank #(
  parameter int DEPTH  = 8,
  parameter int DATA_W = 32,
  parameter int RESP_W = 2,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              alloc_en,
  input  logic [PTR_W-1:0]  alloc_idx,
  input  logic              free_en,
  input  logic [PTR_W-1:0]  free_idx,
  input  logic              wr_en,
  input  logic [PTR_W-1:0]  wr_idx,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [RESP_W-1:0] wr_resp,
  input  logic [PTR_W-1:0]  rd_idx,
  output logic [DEPTH-1:0]  busy,
  output logic [DEPTH-1:0]  filled,
  output logic [DATA_W-1:0] rd_data,
  output logic [RESP_W-1:0] rd_resp
);

  logic [DATA_W-1:0] data_q [DEPTH];
  logic [RESP_W-1:0] resp_q [DEPTH];

  for (genvar s = 0; s < DEPTH; s++) begin : g_slot
    logic hit_alloc, hit_free, hit_wr;
    assign hit_alloc = alloc_en && (alloc_idx == PTR_W'(s));
    assign hit_free  = free_en  && (free_idx  == PTR_W'(s));
    assign hit_wr    = wr_en    && (wr_idx    == PTR_W'(s));

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        busy[s]   <= 1'b0;
        filled[s] <= 1'b0;
      end else begin
        if (hit_alloc) busy[s] <= 1'b1;
        if (hit_wr)    filled[s] <= 1'b1;
        if (hit_free) begin
          busy[s]   <= 1'b0;
          filled[s] <= 1'b0;
        end
      end
    end

    always_ff @(posedge clk) begin
      if (hit_wr) begin
        data_q[s] <= wr_data;
        resp_q[s] <= wr_resp;
      end
    end
  end

  assign rd_data = data_q[rd_idx];
  assign rd_resp = resp_q[rd_idx];

endmodule

// File: rtl/rob_resp_match.sv
module rob_resp_match #(
  parameter int DEPTH = 8,
  parameter int ID_W  = 4,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             r_valid,
  input  logic [ID_W-1:0]  r_id,
  input  logic [DEPTH-1:0] busy,
  input  logic [DEPTH-1:0] filled,
  output logic             hit,
  output logic             miss,
  output logic [PTR_W-1:0] idx
);
  import rob_pkg::*;

  logic in_rng;

  always_comb begin
    in_rng = id_in_range(32'(r_id), DEPTH);
    idx    = PTR_W'(r_id);
    hit    = r_valid && in_rng && busy[idx] && !filled[idx];
    miss   = r_valid && !hit;
  end

endmodule

// File: rtl/read_reorder_buf.sv
module read_reorder_buf #(
  parameter int DEPTH  = 8,
  parameter int ID_W   = 4,
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int RESP_W = 2,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  output logic              ar_valid,
  input  logic              ar_ready,
  output logic [ID_W-1:0]   ar_id,
  output logic [ADDR_W-1:0] ar_addr,
  input  logic              r_valid,
  output logic              r_ready,
  input  logic [ID_W-1:0]   r_id,
  input  logic [DATA_W-1:0] r_data,
  input  logic [RESP_W-1:0] r_resp,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [DATA_W-1:0] rsp_data,
  output logic [RESP_W-1:0] rsp_resp,
  output logic              rsp_err
);

  // Named internal events, observed by the bound checker.
  logic [PTR_W-1:0] head_ptr, tail_ptr, cap_idx;
  logic [CNT_W-1:0] occupancy;
  logic             full;
  logic             issue_fire, drain_fire, capture_fire, bad_rsp;
  logic [DEPTH-1:0] slot_busy, slot_full;
  logic             err_q;

  assign ar_valid   = req_valid && !full;
  assign req_ready  = ar_ready && !full;
  assign ar_addr    = req_addr;
  assign ar_id      = ID_W'(tail_ptr);
  assign issue_fire = ar_valid && ar_ready;
  assign r_ready    = 1'b1;

  rob_ring_ctrl #(.DEPTH(DEPTH)) u_ring (
    .clk   (clk),
    .rst_n (rst_n),
    .push  (issue_fire),
    .pop   (drain_fire),
    .head  (head_ptr),
    .tail  (tail_ptr),
    .count (occupancy),
    .full  (full)
  );

  rob_resp_match #(.DEPTH(DEPTH), .ID_W(ID_W)) u_match (
    .r_valid (r_valid),
    .r_id    (r_id),
    .busy    (slot_busy),
    .filled  (slot_full),
    .hit     (capture_fire),
    .miss    (bad_rsp),
    .idx     (cap_idx)
  );

  rob_slot_bank #(.DEPTH(DEPTH), .DATA_W(DATA_W), .RESP_W(RESP_W)) u_bank (
    .clk       (clk),
    .rst_n     (rst_n),
    .alloc_en  (issue_fire),
    .alloc_idx (tail_ptr),
    .free_en   (drain_fire),
    .free_idx  (head_ptr),
    .wr_en     (capture_fire),
    .wr_idx    (cap_idx),
    .wr_data   (r_data),
    .wr_resp   (r_resp),
    .rd_idx    (head_ptr),
    .busy      (slot_busy),
    .filled    (slot_full),
    .rd_data   (rsp_data),
    .rd_resp   (rsp_resp)
  );

  assign rsp_valid  = slot_busy[head_ptr] && slot_full[head_ptr];
  assign drain_fire = rsp_valid && rsp_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) err_q <= 1'b0;
    else        err_q <= bad_rsp;
  end
  assign rsp_err = err_q;

endmodule

// File: rtl/rob_checker.sv
module rob_checker #(
  parameter int DEPTH  = 8,
  parameter int ID_W   = 4,
  parameter int DATA_W = 32,
  parameter int RESP_W = 2,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_ready,
  input logic              ar_valid,
  input logic [ID_W-1:0]   ar_id,
  input logic              rsp_valid,
  input logic              rsp_ready,
  input logic [DATA_W-1:0] rsp_data,
  input logic [RESP_W-1:0] rsp_resp,
  input logic              rsp_err,
  input logic [PTR_W-1:0]  head_ptr,
  input logic [PTR_W-1:0]  cap_idx,
  input logic [CNT_W-1:0]  occupancy,
  input logic              issue_fire,
  input logic              drain_fire,
  input logic              capture_fire,
  input logic              bad_rsp,
  input logic [DEPTH-1:0]  slot_busy,
  input logic [DEPTH-1:0]  slot_full
);

  logic id_taken;
  assign id_taken = slot_busy[PTR_W'(ar_id)];

  AST_ID_UNIQUE: assert property (@(posedge clk) disable iff (!rst_n)
    ar_valid |-> !id_taken); // R2

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (occupancy == CNT_W'(DEPTH)) |-> (!req_ready && !ar_valid)); // R3

  AST_HEAD_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (slot_busy[head_ptr] && slot_full[head_ptr])); // R6

  AST_OCC_TRACK: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> (occupancy == CNT_W'($past(occupancy) + CNT_W'($past(issue_fire))
                                          - CNT_W'($past(drain_fire))))); // R6

  AST_HEAD_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    (capture_fire && cap_idx == head_ptr) |=> rsp_valid); // R5

  AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_data) && $stable(rsp_resp))); // R7

  AST_ERR_RAISE: assert property (@(posedge clk) disable iff (!rst_n)
    bad_rsp |=> rsp_err); // R8

  AST_ERR_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !bad_rsp |=> !rsp_err); // R8

endmodule

bind read_reorder_buf rob_checker #(
  .DEPTH(DEPTH), .ID_W(ID_W), .DATA_W(DATA_W), .RESP_W(RESP_W)
) u_rob_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .req_ready    (req_ready),
  .ar_valid     (ar_valid),
  .ar_id        (ar_id),
  .rsp_valid    (rsp_valid),
  .rsp_ready    (rsp_ready),
  .rsp_data     (rsp_data),
  .rsp_resp     (rsp_resp),
  .rsp_err      (rsp_err),
  .head_ptr     (head_ptr),
  .cap_idx      (cap_idx),
  .occupancy    (occupancy),
  .issue_fire   (issue_fire),
  .drain_fire   (drain_fire),
  .capture_fire (capture_fire),
  .bad_rsp      (bad_rsp),
  .slot_busy    (slot_busy),
  .slot_full    (slot_full)
);

// File: tb/read_reorder_buf_test.sv
module read_reorder_buf_test;
  localparam int DEPTH = 8;
  localparam int ID_W  = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, ar_ready = 1'b1, r_valid = 1'b0, rsp_ready = 1'b1;
  logic [31:0] req_addr = '0, r_data = '0;
  logic [3:0]  r_id = '0;
  logic [1:0]  r_resp = '0;
  logic        req_ready, ar_valid, r_ready, rsp_valid, rsp_err;
  logic [3:0]  ar_id;
  logic [31:0] ar_addr, rsp_data;
  logic [1:0]  rsp_resp;

  always #2.5 clk = ~clk;

  read_reorder_buf #(.DEPTH(DEPTH), .ID_W(ID_W)) uut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .ar_valid(ar_valid), .ar_ready(ar_ready), .ar_id(ar_id), .ar_addr(ar_addr),
    .r_valid(r_valid), .r_ready(r_ready), .r_id(r_id), .r_data(r_data), .r_resp(r_resp),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_data(rsp_data),
    .rsp_resp(rsp_resp), .rsp_err(rsp_err)
  );

  int checks = 0, failures = 0;
  bit done = 1'b0;
  int exp_tail = 0;
  logic [31:0] slot_addr [16];
  logic [31:0] exp_data [$];
  logic [1:0]  exp_resp [$];
  logic [31:0] mon_d;
  logic [1:0]  mon_r;

  function automatic logic [31:0] data_of(logic [31:0] a);
    return {a[15:0], ~a[15:0]};
  endfunction
  function automatic logic [1:0] resp_of(logic [31:0] a);
    return a[3:2];
  endfunction

  task automatic chk(bit ok, string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  // Driver: issue one read and record the expected response.
  task automatic issue(logic [31:0] a);
    @(posedge clk); #1;
    req_valid = 1'b1;
    req_addr  = a;
    do @(negedge clk); while (!req_ready);
    chk(ar_valid == 1'b1, "R10 ar_valid", 64'(ar_valid), 64'd1);
    chk(ar_id == 4'(exp_tail), "R1 ar_id", 64'(ar_id), 64'(exp_tail));
    chk(ar_addr == a, "R10 ar_addr", 64'(ar_addr), 64'(a));
    slot_addr[exp_tail] = a;
    exp_data.push_back(data_of(a));
    exp_resp.push_back(resp_of(a));
    exp_tail = (exp_tail + 1) % DEPTH;
    @(posedge clk); #1;
    req_valid = 1'b0;
  endtask

  // Slave model: one response beat for the given ID.
  task automatic respond(int id);
    @(posedge clk); #1;
    r_valid = 1'b1;
    r_id    = 4'(id);
    r_data  = data_of(slot_addr[id]);
    r_resp  = resp_of(slot_addr[id]);
    @(posedge clk); #1;
    r_valid = 1'b0;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) @(posedge clk);
    #1;
  endtask

  // Monitor: compare each delivered response against the scoreboard.
  always @(negedge clk) begin
    if (rst_n && rsp_valid && rsp_ready) begin
      if (exp_data.size() == 0) begin
        chk(1'b0, "R6 unexpected delivery", 64'(rsp_data), 64'd0);
      end else begin
        mon_d = exp_data.pop_front();
        mon_r = exp_resp.pop_front();
        chk(rsp_data == mon_d, "R6 order data", 64'(rsp_data), 64'(mon_d));
        chk(rsp_resp == mon_r, "R6 order resp", 64'(rsp_resp), 64'(mon_r));
      end
    end
  end

  initial begin
    #500000;
    chk(1'b0, "watchdog", 64'd0, 64'd1);
    finish_run();
  end

  initial begin
    for (int i = 0; i < 16; i++) slot_addr[i] = 32'h0;
    @(negedge clk);
    chk(r_ready == 1'b1, "R4 r_ready in reset", 64'(r_ready), 64'd1);
    idle(3);
    rst_n = 1'b1;
    @(negedge clk);
    chk(rsp_valid == 1'b0, "R9 rsp_valid", 64'(rsp_valid), 64'd0);
    chk(rsp_err == 1'b0, "R9 rsp_err", 64'(rsp_err), 64'd0);
    chk(req_ready == 1'b1, "R9 req_ready", 64'(req_ready), 64'd1);

    // R10: handshake passes through when space exists.
    @(posedge clk); #1; ar_ready = 1'b0; req_valid = 1'b1; req_addr = 32'h55;
    @(negedge clk);
    chk(req_ready == 1'b0, "R10 req_ready follows ar_ready", 64'(req_ready), 64'd0);
    chk(ar_valid == 1'b1, "R10 ar_valid follows req_valid", 64'(ar_valid), 64'd1);
    @(posedge clk); #1; ar_ready = 1'b1; req_valid = 1'b0;

    // Shuffled responses: 3,1 early and held, then 0, then 2.
    issue(32'h1000); issue(32'h1004); issue(32'h1008); issue(32'h100C);
    respond(3); respond(1);
    idle(2);
    @(negedge clk);
    chk(rsp_valid == 1'b0, "R6 early held", 64'(rsp_valid), 64'd0);
    respond(0);
    @(negedge clk);
    chk(rsp_valid == 1'b1, "R5 head latency", 64'(rsp_valid), 64'd1);
    respond(2);
    idle(6);
    chk(exp_data.size() == 0, "R6 all drained", 64'(exp_data.size()), 64'd0);
    chk(r_ready == 1'b1, "R4 r_ready", 64'(r_ready), 64'd1);

    // Fill all slots (IDs wrap 4..7,0..3), reversed answers under backpressure.
    for (int i = 0; i < DEPTH; i++) issue(32'h2000 + 32'(i) * 4);
    @(posedge clk); #1; req_valid = 1'b1; req_addr = 32'h3000;
    @(negedge clk);
    chk(req_ready == 1'b0, "R3 req_ready full", 64'(req_ready), 64'd0);
    chk(ar_valid == 1'b0, "R3 ar_valid full", 64'(ar_valid), 64'd0);
    @(posedge clk); #1; req_valid = 1'b0; rsp_ready = 1'b0;
    for (int k = 0; k < DEPTH; k++) respond((3 - k + DEPTH) % DEPTH);
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk(rsp_valid == 1'b1, "R7 valid held", 64'(rsp_valid), 64'd1);
      chk(rsp_data == exp_data[0], "R7 data held", 64'(rsp_data), 64'(exp_data[0]));
    end
    @(posedge clk); #1; rsp_ready = 1'b1;
    idle(12);
    chk(exp_data.size() == 0, "R6 reverse drained", 64'(exp_data.size()), 64'd0);

    // Unknown IDs: free slot, then out of range.
    respond(5);
    @(negedge clk);
    chk(rsp_err == 1'b1, "R8 err not in flight", 64'(rsp_err), 64'd1);
    @(negedge clk);
    chk(rsp_err == 1'b0, "R8 err one cycle", 64'(rsp_err), 64'd0);
    chk(rsp_valid == 1'b0, "R8 dropped", 64'(rsp_valid), 64'd0);
    respond(12);
    @(negedge clk);
    chk(rsp_err == 1'b1, "R8 err out of range", 64'(rsp_err), 64'd1);

    // Duplicate response for a filled slot is dropped.
    @(posedge clk); #1; rsp_ready = 1'b0;
    issue(32'h4440);
    respond(4);
    @(negedge clk);
    chk(rsp_err == 1'b0, "R8 valid beat no err", 64'(rsp_err), 64'd0);
    respond(4);
    @(negedge clk);
    chk(rsp_err == 1'b1, "R8 err duplicate", 64'(rsp_err), 64'd1);
    @(posedge clk); #1; rsp_ready = 1'b1;
    idle(6);
    chk(exp_data.size() == 0, "R8 single delivery", 64'(exp_data.size()), 64'd0);
    @(negedge clk);
    chk(rsp_valid == 1'b0, "R8 no extra delivery", 64'(rsp_valid), 64'd0);

    finish_run();
  end

endmodule